// File: doc/BRIEF.md
# Priority interrupt mask controller

This block keeps a processor's event mask state and its three-bit execution mode. Four prioritized interrupt levels, a non-maskable interrupt, an exception request, a debug-entry pulse and a trap entry/return pair act on that state. Each cycle the block picks at most one event to accept. On acceptance it updates the mode and the mask bits, and it saves the prior state in a one-deep shadow.

Software reads and writes the mask bits through a plain register port. The `evt_ret_i` pulse puts back the saved mode and masks. Accepting a level raises the masks of that level and of every level below it. A global mask blocks all four levels at once.

The mask word has this layout:
- bit 5: global mask
- bit 4: exception mask
- bits 3 to 0: masks for interrupt levels 3 to 0

Top module: `irq_mask_ctrl`

## Requirements
- R1: After reset the mask word is 6'b110000 (global and exception masks set, level masks clear). The mode is 3'b001 (supervisor).
- R2: A level-n request is accepted only while mask bit n and the global mask (bit 5) are both clear.
- R3: Accepting level n drives `accept_o` high in the same cycle with `accept_mode_o` = 2+n. On the next edge the mode becomes 2+n and mask bits n down to 0 are set.
- R4: Priority, highest first, is NMI, exception, level 3, level 2, level 1, level 0. At most one event is accepted per cycle.
- R5: A rising edge on `nmi_i` is accepted in that cycle regardless of every mask bit. It uses mode 3'b111, sets bits 5 and 4, and a held-high `nmi_i` is not accepted again.
- R6: The exception request is blocked only by the exception mask (bit 4). Its acceptance gives mode 3'b110 and sets bits 5 and 4.
- R7: A debug-entry pulse sets bits 5 and 4 and leaves the mode unchanged.
- R8: Trap entry sets the global mask. Trap return clears it. The mode is unchanged by both.
- R9: A software write replaces the whole mask word, so any bit can be cleared to allow nested handling.
- R10: Each acceptance saves the prior mode and mask word. An `evt_ret_i` pulse restores both on the next edge, and no event is accepted in that cycle.
- R11: A request blocked by a mask stays pending. It is accepted as soon as the masks allow it.
- R12: A software write is ignored in any cycle in which an event is accepted, or in which debug entry, a trap action or a return occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_req_i | input | 4 | Level-sensitive interrupt requests, bit n is level n |
| nmi_i | input | 1 | Non-maskable interrupt, edge-detected |
| exc_req_i | input | 1 | Exception request, level-sensitive |
| dbg_enter_i | input | 1 | Debug-entry pulse |
| trap_enter_i | input | 1 | Trap entry pulse |
| trap_ret_i | input | 1 | Trap return pulse |
| evt_ret_i | input | 1 | Return-from-event pulse |
| sw_we_i | input | 1 | Software mask write enable |
| sw_wdata_i | input | 6 | Software mask write data |
| sw_rdata_o | output | 6 | Current mask word |
| mode_o | output | 3 | Current execution mode |
| accept_o | output | 1 | An event is accepted this cycle |
| accept_mode_o | output | 3 | Mode of the event being accepted |

## Verification
A corrupted mask bit shows up at the ports in two ways. It reads back wrongly on `sw_rdata_o` at once. It also shows in the next cycle, when a request is granted that should have been blocked, or refused when it should have been granted. A bad arbitration decision is visible combinationally on `accept_mode_o` in the very cycle of the request. A wrong shadow stays hidden until the next `evt_ret_i`, so the tests pair every nested acceptance with a return and then check the restored mode and masks one edge later.

// File: rtl/irq_mask_pkg.sv
package irq_mask_pkg;
  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    MODE_APP = 3'b000,
    MODE_SUP = 3'b001,
    MODE_L0  = 3'b010,
    MODE_L1  = 3'b011,
    MODE_L2  = 3'b100,
    MODE_L3  = 3'b101,
    MODE_EXC = 3'b110,
    MODE_NMI = 3'b111
  } mode_e;
endpackage

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_mask_pkg::*;
#(
  parameter int N_LVL = 4
) (
  input  logic [N_LVL-1:0] lvl_req_i,
  input  logic [N_LVL+1:0] mask_i,
  input  logic             exc_req_i,
  input  logic             nmi_act_i,
  input  logic             en_i,
  output logic             grant_o,
  output mode_e            grant_mode_o,
  output logic [N_LVL+1:0] set_mask_o,
  output logic             nmi_take_o
);
  localparam int MASK_W   = N_LVL + 2;
  localparam int GLOB_BIT = N_LVL + 1;
  localparam int EXC_BIT  = N_LVL;

  logic [N_LVL-1:0] lvl_ok;

  for (genvar g = 0; g < N_LVL; g++) begin : g_lvl
    assign lvl_ok[g] = lvl_req_i[g] & ~mask_i[g] & ~mask_i[GLOB_BIT];
  end

  // ascending scan: the highest eligible level overwrites lower ones
  always_comb begin
    grant_o      = 1'b0;
    grant_mode_o = MODE_SUP;
    set_mask_o   = '0;
    nmi_take_o   = 1'b0;
    for (int n = 0; n < N_LVL; n++) begin
      if (lvl_ok[n]) begin
        grant_o      = 1'b1;
        grant_mode_o = mode_e'(MODE_W'(2 + n));
        for (int b = 0; b < MASK_W; b++) set_mask_o[b] = (b <= n);
      end
    end
    if (exc_req_i && !mask_i[EXC_BIT]) begin
      grant_o      = 1'b1;
      grant_mode_o = MODE_EXC;
      set_mask_o   = '0;
      set_mask_o[GLOB_BIT] = 1'b1;
      set_mask_o[EXC_BIT]  = 1'b1;
    end
    if (nmi_act_i) begin
      grant_o      = 1'b1;
      grant_mode_o = MODE_NMI;
      set_mask_o   = '0;
      set_mask_o[GLOB_BIT] = 1'b1;
      set_mask_o[EXC_BIT]  = 1'b1;
      nmi_take_o   = 1'b1;
    end
    if (!en_i) begin
      grant_o    = 1'b0;
      set_mask_o = '0;
      nmi_take_o = 1'b0;
    end
  end
endmodule

// File: rtl/mask_regs.sv
module mask_regs
  import irq_mask_pkg::*;
#(
  parameter int N_LVL = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             grant_i,
  input  mode_e            grant_mode_i,
  input  logic [N_LVL+1:0] set_mask_i,
  input  logic             ret_i,
  input  logic             dbg_i,
  input  logic             trap_in_i,
  input  logic             trap_out_i,
  input  logic             sw_we_i,
  input  logic [N_LVL+1:0] sw_wdata_i,
  output logic [N_LVL+1:0] mask_o,
  output mode_e            mode_o
);
  localparam int MASK_W   = N_LVL + 2;
  localparam int GLOB_BIT = N_LVL + 1;
  localparam int EXC_BIT  = N_LVL;
  localparam logic [MASK_W-1:0] MASK_RST = MASK_W'(3) << N_LVL;

  logic [MASK_W-1:0] mask_q, shd_mask_q;
  mode_e             mode_q, shd_mode_q;

  // one action per cycle: return > accept > debug > trap in > trap out > software
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q     <= MASK_RST;
      mode_q     <= MODE_SUP;
      shd_mask_q <= MASK_RST;
      shd_mode_q <= MODE_SUP;
    end else if (ret_i) begin
      mask_q <= shd_mask_q;
      mode_q <= shd_mode_q;
    end else if (grant_i) begin
      shd_mask_q <= mask_q;
      shd_mode_q <= mode_q;
      mask_q     <= mask_q | set_mask_i;
      mode_q     <= grant_mode_i;
    end else if (dbg_i) begin
      mask_q[GLOB_BIT] <= 1'b1;
      mask_q[EXC_BIT]  <= 1'b1;
    end else if (trap_in_i) begin
      mask_q[GLOB_BIT] <= 1'b1;
    end else if (trap_out_i) begin
      mask_q[GLOB_BIT] <= 1'b0;
    end else if (sw_we_i) begin
      mask_q <= sw_wdata_i;
    end
  end

  assign mask_o = mask_q;
  assign mode_o = mode_q;

  p_ret_restore_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_i |=> (mode_q == $past(shd_mode_q)) && (mask_q == $past(shd_mask_q)));

  p_trap_ret_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_out_i && !ret_i && !grant_i && !dbg_i && !trap_in_i) |=> !mask_q[GLOB_BIT]);

  p_dbg_mode_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_i && !ret_i && !grant_i) |=> (mode_q == $past(mode_q)) && mask_q[EXC_BIT]);
endmodule

// File: rtl/irq_mask_ctrl.sv
module irq_mask_ctrl
  import irq_mask_pkg::*;
#(
  parameter int N_LVL = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_LVL-1:0] irq_req_i,
  input  logic             nmi_i,
  input  logic             exc_req_i,
  input  logic             dbg_enter_i,
  input  logic             trap_enter_i,
  input  logic             trap_ret_i,
  input  logic             evt_ret_i,
  input  logic             sw_we_i,
  input  logic [N_LVL+1:0] sw_wdata_i,
  output logic [N_LVL+1:0] sw_rdata_o,
  output logic [2:0]       mode_o,
  output logic             accept_o,
  output logic [2:0]       accept_mode_o
);
  localparam int GLOB_BIT = N_LVL + 1;
  localparam int EXC_BIT  = N_LVL;

  logic             nmi_q, nmi_pend_q, nmi_act, nmi_take;
  logic             grant;
  mode_e            grant_mode, mode;
  logic [N_LVL+1:0] set_mask, mask;

  // edge-detected NMI, held pending until taken
  assign nmi_act = nmi_pend_q | (nmi_i & ~nmi_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nmi_q      <= 1'b0;
      nmi_pend_q <= 1'b0;
    end else begin
      nmi_q      <= nmi_i;
      nmi_pend_q <= nmi_act & ~nmi_take;
    end
  end

  irq_arbiter #(.N_LVL(N_LVL)) u_arb (
    .lvl_req_i    (irq_req_i),
    .mask_i       (mask),
    .exc_req_i    (exc_req_i),
    .nmi_act_i    (nmi_act),
    .en_i         (~evt_ret_i),
    .grant_o      (grant),
    .grant_mode_o (grant_mode),
    .set_mask_o   (set_mask),
    .nmi_take_o   (nmi_take)
  );

  mask_regs #(.N_LVL(N_LVL)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .grant_i      (grant),
    .grant_mode_i (grant_mode),
    .set_mask_i   (set_mask),
    .ret_i        (evt_ret_i),
    .dbg_i        (dbg_enter_i),
    .trap_in_i    (trap_enter_i),
    .trap_out_i   (trap_ret_i),
    .sw_we_i      (sw_we_i),
    .sw_wdata_i   (sw_wdata_i),
    .mask_o       (mask),
    .mode_o       (mode)
  );

  assign sw_rdata_o    = mask;
  assign mode_o        = mode;
  assign accept_o      = grant;
  assign accept_mode_o = grant_mode;

  for (genvar g = 0; g < N_LVL; g++) begin : g_chk
    p_lvl_gate_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (accept_o && accept_mode_o == 3'(2 + g)) |-> (!mask[g] && !mask[GLOB_BIT]));
    p_cascade_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (accept_o && accept_mode_o == 3'(2 + g)) |=> ((&mask[g:0]) && mode_o == 3'(2 + g)));
  end

  p_nmi_edge_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nmi_i && !nmi_q && !evt_ret_i) |-> (accept_o && accept_mode_o == 3'b111));

  p_exc_over_lvl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_req_i && !mask[EXC_BIT] && !nmi_act && !evt_ret_i) |-> (accept_o && accept_mode_o == 3'b110));
endmodule

// File: tb/irq_mask_ctrl_test.sv
module irq_mask_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] irq = '0;
  logic       nmi = 1'b0, exc = 1'b0, dbg = 1'b0, tin = 1'b0, tout = 1'b0, ret = 1'b0;
  logic       we = 1'b0;
  logic [5:0] wdata = '0;
  logic [5:0] rdata;
  logic [2:0] mode, acc_mode;
  logic       acc;
  int         n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  irq_mask_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .irq_req_i(irq), .nmi_i(nmi), .exc_req_i(exc),
    .dbg_enter_i(dbg), .trap_enter_i(tin), .trap_ret_i(tout), .evt_ret_i(ret),
    .sw_we_i(we), .sw_wdata_i(wdata), .sw_rdata_o(rdata), .mode_o(mode),
    .accept_o(acc), .accept_mode_o(acc_mode)
  );

  task automatic chk(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic set_mask(logic [5:0] v);
    we = 1'b1; wdata = v;
    tick();
    we = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 mask", rdata, 6'h30);
    chk("R1 mode", mode, 3'b001);
    irq = 4'hF; #1;
    chk("R2 global blocks", acc, 0);
    irq = 4'h0;
  endtask

  task automatic t_nested();
    set_mask(6'h00);
    chk("R9 write", rdata, 6'h00);
    irq = 4'b0010; #1;
    chk("R3 accept l1", acc, 1);
    chk("R3 mode l1 comb", acc_mode, 3'b011);
    tick();
    chk("R3 mask l1", rdata, 6'h03);
    chk("R3 mode l1", mode, 3'b011);
    #1 chk("R2 own mask", acc, 0);
    irq = 4'b0110; #1;
    chk("R3 nested l2", acc_mode, 3'b100);
    tick();
    chk("R3 mask l2", rdata, 6'h07);
    chk("R3 mode l2", mode, 3'b100);
    irq = 4'h0; ret = 1'b1;
    tick();
    ret = 1'b0;
    chk("R10 mode restore", mode, 3'b011);
    chk("R10 mask restore", rdata, 6'h03);
  endtask

  task automatic t_prio();
    set_mask(6'h00);
    irq = 4'b1001; exc = 1'b1; #1;
    chk("R4 exc wins", acc_mode, 3'b110);
    tick();
    exc = 1'b0;
    chk("R6 exc masks", rdata, 6'h30);
    chk("R6 exc mode", mode, 3'b110);
    #1 chk("R11 blocked", acc, 0);
    set_mask(6'h00);
    #1 chk("R11 pending l3 taken", acc_mode, 3'b101);
    chk("R11 accept", acc, 1);
    tick();
    irq = 4'h0;
    chk("R4 l3 masks", rdata, 6'h0F);
    chk("R4 l3 mode", mode, 3'b101);
  endtask

  task automatic t_nmi();
    set_mask(6'h3F);
    nmi = 1'b1; #1;
    chk("R5 nmi accept", acc, 1);
    chk("R5 nmi mode comb", acc_mode, 3'b111);
    tick();
    chk("R5 nmi mode", mode, 3'b111);
    chk("R5 masks", rdata, 6'h3F);
    #1 chk("R5 no re-accept", acc, 0);
    nmi = 1'b0;
    tick();
  endtask

  task automatic t_exc();
    set_mask(6'h10);
    exc = 1'b1; #1;
    chk("R6 exc masked", acc, 0);
    tick();
    chk("R6 mode kept", mode, 3'b111);
    set_mask(6'h00);
    #1 chk("R6 exc taken", acc_mode, 3'b110);
    tick();
    exc = 1'b0;
    chk("R6 masks", rdata, 6'h30);
    chk("R6 mode", mode, 3'b110);
  endtask

  task automatic t_dbg_trap();
    set_mask(6'h00);
    dbg = 1'b1;
    tick();
    dbg = 1'b0;
    chk("R7 dbg masks", rdata, 6'h30);
    chk("R7 mode kept", mode, 3'b110);
    set_mask(6'h00);
    tin = 1'b1;
    tick();
    tin = 1'b0;
    chk("R8 trap enter", rdata, 6'h20);
    tout = 1'b1;
    tick();
    tout = 1'b0;
    chk("R8 trap return", rdata, 6'h00);
    chk("R8 mode kept", mode, 3'b110);
  endtask

  task automatic t_sw_block();
    set_mask(6'h00);
    irq = 4'b0100; we = 1'b1; wdata = 6'h00; #1;
    chk("R12 accept", acc, 1);
    tick();
    we = 1'b0; irq = 4'h0;
    chk("R12 hw wins", rdata, 6'h07);
    chk("R12 mode", mode, 3'b100);
    dbg = 1'b1; we = 1'b1; wdata = 6'h00;
    tick();
    dbg = 1'b0; we = 1'b0;
    chk("R12 dbg over write", rdata, 6'h37);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    #1;
    t_reset();
    t_nested();
    t_prio();
    t_nmi();
    t_exc();
    t_dbg_trap();
    t_sw_block();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule